// File: doc/BRIEF.md
# Self-Synchronizing 20-Bit Scrambler and Descrambler Pair

This block holds two independent datapaths that carry 20-bit words, each made of two 10-bit line code groups. The transmit path scrambles each word with a multiplicative scrambler whose feedback polynomial is a 32-bit programmable mask. The receive path undoes this with a descrambler that takes its feedback from the received line bits. Because of that, the receive path falls into step with any transmitter using the same polynomial within 32 line bits, and it needs no start-up exchange. Each path has its own enable and its own polynomial input.

After descrambling, the receive path checks each 10-bit group against a structural 8b/10b validity rule. A group that fails is replaced by the error code K30.7, and a per-group flag is raised. A line error that turns a group into something illegal therefore cannot reach later logic as a marker character. Both paths have a single output register, so a word comes out one cycle after it is accepted, and this holds whether or not the path is enabled.

Each path's input and output is a valid/ready stream. A word moves on a cycle where valid and ready are both high. The input side is ready whenever the output register is empty or is being drained in that cycle. While the output is stalled, its data and error flags do not change. The scrambler history advances only on a transfer, so a stall does not alter the scrambled sequence.

Top module: `mscr_pair`

## Requirements
- R1: After reset, `tx_out_valid` and `rx_out_valid` are low, both `*_in_ready` are high, and both shift histories hold all zeros.
- R2: A word accepted on an input (valid and ready high at a clock edge) is presented on the matching output with valid high right after that edge. An input is ready when its output is empty or the output's ready is high.
- R3: While an output has valid high and ready low, its data (and error flags) hold steady and its input's ready is low. The history advances once per accepted word, never on a stalled cycle.
- R4: With `tx_en` high, input bits are scrambled bit 19 first down to bit 0. Each sent bit s(t) = d(t) XOR the XOR of s(t-k) over every k in 1..32 with `tx_poly[k]` set. The history is fed by the sent bits.
- R5: With `rx_en` high, each received bit r(t) yields d(t) = r(t) XOR the XOR of r(t-k) over every k with `rx_poly[k]` set. The history is fed by the received bits, so output follows the transmitter exactly from 32 line bits after any starting state.
- R6: With equal polynomials and both sides enabled, feeding the transmit output into the receive input restores every transmitted word unchanged, for any mask.
- R7: With an enable low, that path outputs its input unchanged, and the receive path raises no error flag. The history keeps being fed by the line bits, so re-enabling continues the sequence seamlessly.
- R8: A group with bits 9..4 as the 6-bit part and bits 3..0 as the 4-bit part is legal when all of these hold: the 6-bit part has 2 to 4 ones and is neither 111100 nor 000011; the 4-bit part has 1 to 3 ones; and the two parts are not both +2 (4 and 3 ones) or both -2 (2 and 1 ones).
- R9: With `rx_en` high, an illegal descrambled group is replaced by 10'h1E8 (K30.7), and its flag is raised. `rx_out_err[1]` covers bits 19..10 and `rx_out_err[0]` covers bits 9..0.
- R10: A single flipped line bit corrupts the descrambled word that holds it, and it can also corrupt output bits up to the highest set tap later, but no further. With a highest tap of 16, every word from the second word after the flip is exact again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Scrambling enable |
| tx_poly | input | 32 | Transmit tap mask, bit k selects x^k (indexed 32..1) |
| tx_in_valid | input | 1 | Transmit input word valid |
| tx_in_ready | output | 1 | Transmit input ready |
| tx_in_data | input | 20 | Plain word, two code groups |
| tx_out_valid | output | 1 | Scrambled word valid |
| tx_out_ready | input | 1 | Downstream ready for scrambled word |
| tx_out_data | output | 20 | Scrambled word |
| rx_en | input | 1 | Descrambling and checking enable |
| rx_poly | input | 32 | Receive tap mask, bit k selects x^k (indexed 32..1) |
| rx_in_valid | input | 1 | Received word valid |
| rx_in_ready | output | 1 | Receive input ready |
| rx_in_data | input | 20 | Line word |
| rx_out_valid | output | 1 | Descrambled word valid |
| rx_out_ready | input | 1 | Downstream ready for descrambled word |
| rx_out_data | output | 20 | Descrambled word with substitutions |
| rx_out_err | output | 2 | Per-group substitution flags |

## Verification
The hardest states to reach from the ports are the receive history holding unrelated bits, and a single bit upset on an otherwise clean line. Both decide whether self-synchronization and bounded error spread really hold. The bench drives junk words into the receive side alone before connecting it to the transmitter's output. It also flips one line bit between the two paths at a chosen word, then counts how many following words differ from what was sent. Illegal groups after descrambling come from a zero tap mask, which turns the descrambler into a wire, together with hand-picked codes that break each part of the legality rule.

// File: rtl/mscr_pkg.sv
`timescale 1ns/1ps
package mscr_pkg;
  localparam int GROUP_W = 10;
  // K30.7, running disparity negative, bit 9 = first line bit
  localparam logic [GROUP_W-1:0] ERR_GROUP = 10'h1E8;
endpackage

// File: rtl/mscr_core.sv
`timescale 1ns/1ps
module mscr_core #(
  parameter int WORD_W = 20,
  parameter int POLY_W = 32,
  parameter bit DESCR  = 1'b0
) (
  input  logic              en,
  input  logic [POLY_W:1]   poly,
  input  logic [POLY_W:1]   hist,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic [POLY_W:1]   hist_nx
);
  generate
    if (DESCR) begin : g_descr
      always_comb begin
        logic [POLY_W:1]   h;
        logic [WORD_W-1:0] o;
        logic              fb;
        h = hist;
        o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
          fb   = ^(poly & h);
          o[i] = en ? (din[i] ^ fb) : din[i];
          h    = {h[POLY_W-1:1], din[i]};
        end
        dout    = o;
        hist_nx = h;
      end
    end else begin : g_scr
      always_comb begin
        logic [POLY_W:1]   h;
        logic [WORD_W-1:0] o;
        logic              fb;
        h = hist;
        o = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
          fb   = ^(poly & h);
          o[i] = en ? (din[i] ^ fb) : din[i];
          h    = {h[POLY_W-1:1], o[i]};
        end
        dout    = o;
        hist_nx = h;
      end
    end
  endgenerate
endmodule

// File: rtl/mscr_code_check.sv
`timescale 1ns/1ps
module mscr_code_check
  import mscr_pkg::*;
(
  input  logic [GROUP_W-1:0] grp,
  output logic               legal
);
  logic [5:0] six;
  logic [3:0] four;
  logic [2:0] w6;
  logic [2:0] w4;
  logic       six_ok, four_ok, disp_ok;

  assign six  = grp[9:4];
  assign four = grp[3:0];

  always_comb begin
    w6 = '0;
    w4 = '0;
    for (int i = 0; i < 6; i++) w6 = w6 + 3'(six[i]);
    for (int i = 0; i < 4; i++) w4 = w4 + 3'(four[i]);
  end

  assign six_ok  = (w6 >= 3'd2) && (w6 <= 3'd4) && (six != 6'b111100) && (six != 6'b000011);
  assign four_ok = (w4 >= 3'd1) && (w4 <= 3'd3);
  assign disp_ok = !((w6 == 3'd4) && (w4 == 3'd3)) && !((w6 == 3'd2) && (w4 == 3'd1));
  assign legal   = six_ok && four_ok && disp_ok;
endmodule

// File: rtl/mscr_pipe_reg.sv
`timescale 1ns/1ps
module mscr_pipe_reg #(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/mscr_pair.sv
`timescale 1ns/1ps
module mscr_pair
  import mscr_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int POLY_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [POLY_W:1]   tx_poly,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [WORD_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [WORD_W-1:0] tx_out_data,
  input  logic              rx_en,
  input  logic [POLY_W:1]   rx_poly,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [WORD_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [WORD_W-1:0] rx_out_data,
  output logic [WORD_W/GROUP_W-1:0] rx_out_err
);
  localparam int NGRP = WORD_W / GROUP_W;

  // transmit path
  logic [POLY_W:1]   tx_hist, tx_hist_nx;
  logic [WORD_W-1:0] tx_scr;
  logic              tx_acc;

  assign tx_acc = tx_in_valid && tx_in_ready;

  mscr_core #(.WORD_W(WORD_W), .POLY_W(POLY_W), .DESCR(1'b0)) i_tx_core (
    .en(tx_en), .poly(tx_poly), .hist(tx_hist), .din(tx_in_data),
    .dout(tx_scr), .hist_nx(tx_hist_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      tx_hist <= '0;
    else if (tx_acc) tx_hist <= tx_hist_nx;
  end

  mscr_pipe_reg #(.DATA_W(WORD_W)) i_tx_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_scr),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data)
  );

  // receive path
  logic [POLY_W:1]   rx_hist, rx_hist_nx;
  logic [WORD_W-1:0] rx_raw, rx_word;
  logic [NGRP-1:0]   rx_sub;
  logic              rx_acc;

  assign rx_acc = rx_in_valid && rx_in_ready;

  mscr_core #(.WORD_W(WORD_W), .POLY_W(POLY_W), .DESCR(1'b1)) i_rx_core (
    .en(rx_en), .poly(rx_poly), .hist(rx_hist), .din(rx_in_data),
    .dout(rx_raw), .hist_nx(rx_hist_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rx_hist <= '0;
    else if (rx_acc) rx_hist <= rx_hist_nx;
  end

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic legal;
      mscr_code_check i_chk (.grp(rx_raw[g*GROUP_W +: GROUP_W]), .legal(legal));
      assign rx_sub[g] = rx_en && !legal;
      assign rx_word[g*GROUP_W +: GROUP_W] = rx_sub[g] ? ERR_GROUP : rx_raw[g*GROUP_W +: GROUP_W];

      // R9
      err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out_valid && rx_out_err[g]) |-> (rx_out_data[g*GROUP_W +: GROUP_W] == ERR_GROUP));
    end
  endgenerate

  mscr_pipe_reg #(.DATA_W(WORD_W + NGRP)) i_rx_reg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data({rx_sub, rx_word}),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data({rx_out_err, rx_out_data})
  );

  // R7
  tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_acc && !tx_en) |=> (tx_out_data == $past(tx_in_data)));

  // R7
  rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_acc && !rx_en) |=> (rx_out_err == '0 && rx_out_data == $past(rx_in_data)));
endmodule

// File: tb/test_mscr_pair.sv
`timescale 1ns/1ps
module test_mscr_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b1, rx_en = 1'b1;
  logic [32:1] tx_poly = '0, rx_poly = '0;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic [19:0] tx_in_data = '0, rx_in_data = '0;
  logic        tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [19:0] tx_out_data, rx_out_data;
  logic [1:0]  rx_out_err;

  int nchk = 0, nfail = 0;
  logic [32:1] mtx_h, mrx_h;

  always #5 clk = ~clk;

  mscr_pair i_mscr_pair (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_poly(tx_poly), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data),
    .rx_en(rx_en), .rx_poly(rx_poly), .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_out_err(rx_out_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 legality rule, recomputed in the bench
  function automatic bit legal10(input logic [9:0] g);
    int a = $countones(g[9:4]);
    int b = $countones(g[3:0]);
    if (a < 2 || a > 4 || g[9:4] == 6'b111100 || g[9:4] == 6'b000011) return 1'b0;
    if (b < 1 || b > 3) return 1'b0;
    if ((a == 4 && b == 3) || (a == 2 && b == 1)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [19:0] rand_word();
    logic [9:0] hi, lo;
    do hi = 10'($urandom); while (!legal10(hi));
    do lo = 10'($urandom); while (!legal10(lo));
    return {hi, lo};
  endfunction

  task automatic model_tx(input logic [19:0] d, output logic [19:0] o);
    for (int i = 19; i >= 0; i--) begin
      o[i]  = tx_en ? (d[i] ^ (^(tx_poly & mtx_h))) : d[i];
      mtx_h = {mtx_h[31:1], o[i]};
    end
  endtask

  task automatic model_rx(input logic [19:0] r, output logic [19:0] o, output logic [1:0] e);
    for (int i = 19; i >= 0; i--) begin
      o[i]  = rx_en ? (r[i] ^ (^(rx_poly & mrx_h))) : r[i];
      mrx_h = {mrx_h[31:1], r[i]};
    end
    e = 2'b00;
    if (rx_en) begin
      if (!legal10(o[19:10])) begin o[19:10] = 10'h1E8; e[1] = 1'b1; end
      if (!legal10(o[9:0]))   begin o[9:0]   = 10'h1E8; e[0] = 1'b1; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    mtx_h = '0; mrx_h = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one transfer per enabled side; outputs sampled on the following falling edge
  task automatic step(input bit tv, input logic [19:0] td, input bit rv, input logic [19:0] rd,
                      output logic [19:0] to, output logic [19:0] ro, output logic [1:0] re);
    logic [19:0] et, er;
    logic [1:0]  ee;
    @(negedge clk);
    tx_in_valid = tv; tx_in_data = td; rx_in_valid = rv; rx_in_data = rd;
    @(negedge clk);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    to = tx_out_data; ro = rx_out_data; re = rx_out_err;
    if (tv) begin
      model_tx(td, et);
      chk(tx_out_valid === 1'b1, "R2 tx valid", 32'(tx_out_valid), 32'd1);
      chk(tx_out_data === et, tx_en ? "R4 tx data" : "R7 tx bypass", 32'(tx_out_data), 32'(et));
    end
    if (rv) begin
      model_rx(rd, er, ee);
      chk(rx_out_valid === 1'b1, "R2 rx valid", 32'(rx_out_valid), 32'd1);
      chk(rx_out_data === er, rx_en ? "R5 rx data" : "R7 rx bypass", 32'(rx_out_data), 32'(er));
      chk(rx_out_err === ee, "R9 rx err", 32'(rx_out_err), 32'(ee));
    end
  endtask

  // stream n words through tx, loop tx output into rx (optional flip, optional junk preload)
  task automatic run_loop(input logic [32:1] p, input int n, input int flip_at, input int junk);
    logic [19:0] src[64];
    logic [19:0] prev, to, ro, rin;
    logic [1:0]  re;
    int last_bad = -1;
    tx_poly = p; rx_poly = p; tx_en = 1'b1; rx_en = 1'b1;
    do_reset();
    for (int j = 0; j < junk; j++) step(1'b0, '0, 1'b1, 20'($urandom), to, ro, re);
    prev = '0;
    for (int j = 0; j <= n; j++) begin
      if (j < n) src[j] = rand_word();
      rin = prev;
      if (j - 1 == flip_at) rin[5] = ~rin[5];
      step(j < n, (j < n) ? src[j] : 20'h0, j > 0, rin, to, ro, re);
      if (j > 0) begin
        int w = j - 1;
        if (flip_at >= 0 && w == flip_at) begin
          chk(ro !== src[w], "R10 flip word differs", 32'(ro), 32'(src[w]));
        end else if (flip_at >= 0 && w == flip_at + 1) begin
          last_bad = w;
        end else if (w >= junk * 0 + ((junk > 0) ? 2 : 0)) begin
          chk(ro === src[w],
              (flip_at >= 0) ? "R10 recovered" : ((junk > 0) ? "R5 self sync" : "R6 round trip"),
              32'(ro), 32'(src[w]));
        end
      end
      prev = to;
    end
  endtask

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [19:0] to, ro, a, b, ea, eb;
    logic [1:0]  re;
    logic [32:1] p;
    void'($urandom(32'd1234));
    mtx_h = '0; mrx_h = '0;
    do_reset();

    // R1 reset state
    chk(tx_out_valid === 1'b0, "R1 tx valid", 32'(tx_out_valid), 0);
    chk(rx_out_valid === 1'b0, "R1 rx valid", 32'(rx_out_valid), 0);
    chk(tx_in_ready === 1'b1 && rx_in_ready === 1'b1, "R1 ready", 32'({tx_in_ready, rx_in_ready}), 3);

    // R8 R9 directed: zero mask makes descrambler a wire
    rx_poly = '0; rx_en = 1'b1;
    step(1'b0, '0, 1'b1, {10'h3FF, 10'h0FA}, to, ro, re);
    chk(ro === {10'h1E8, 10'h0FA} && re === 2'b10, "R9 upper sub", 32'({re, ro}), 32'({2'b10, 10'h1E8, 10'h0FA}));
    step(1'b0, '0, 1'b1, {10'h0FA, 10'h3C5}, to, ro, re);
    chk(ro === {10'h0FA, 10'h1E8} && re === 2'b01, "R8 six-bit 111100", 32'({re, ro}), 32'({2'b01, 10'h0FA, 10'h1E8}));
    step(1'b0, '0, 1'b1, {10'h27B, 10'h1E8}, to, ro, re);
    chk(re === 2'b10, "R8 disparity clash", 32'(re), 32'd2);
    step(1'b0, '0, 1'b1, {10'h305, 10'h1C6}, to, ro, re);
    chk(re === 2'b00 && ro === {10'h305, 10'h1C6}, "R8 legal pass", 32'({re, ro}), 32'({2'b00, 10'h305, 10'h1C6}));

    // R7 rx disabled: illegal group passes, no flag
    rx_en = 1'b0;
    step(1'b0, '0, 1'b1, 20'hFFFFF, to, ro, re);
    chk(ro === 20'hFFFFF && re === 2'b00, "R7 rx off", 32'({re, ro}), 32'hFFFFF);
    rx_en = 1'b1;

    // R7 tx disabled then re-enabled: history keeps feeding
    tx_poly = '0; tx_poly[16] = 1'b1; tx_poly[15] = 1'b1; tx_poly[13] = 1'b1; tx_poly[4] = 1'b1;
    step(1'b1, rand_word(), 1'b0, '0, to, ro, re);
    tx_en = 1'b0;
    a = rand_word();
    step(1'b1, a, 1'b0, '0, to, ro, re);
    chk(to === a, "R7 tx off", 32'(to), 32'(a));
    step(1'b1, rand_word(), 1'b0, '0, to, ro, re);
    tx_en = 1'b1;
    repeat (3) step(1'b1, rand_word(), 1'b0, '0, to, ro, re);

    // R3 back-pressure
    a = rand_word(); b = rand_word();
    @(negedge clk);
    tx_out_ready = 1'b0; tx_in_valid = 1'b1; tx_in_data = a;
    @(negedge clk);
    model_tx(a, ea);
    chk(tx_out_valid === 1'b1 && tx_out_data === ea, "R3 first word", 32'(tx_out_data), 32'(ea));
    tx_in_data = b;
    chk(tx_in_ready === 1'b0, "R3 ready low", 32'(tx_in_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_out_valid === 1'b1 && tx_out_data === ea, "R3 hold", 32'(tx_out_data), 32'(ea));
    end
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    model_tx(b, eb);
    chk(tx_out_data === eb, "R3 history once", 32'(tx_out_data), 32'(eb));
    @(negedge clk);
    chk(tx_out_valid === 1'b0, "R2 drained", 32'(tx_out_valid), 0);

    // R6 round trip, example mask and random masks
    p = '0; p[16] = 1'b1; p[15] = 1'b1; p[13] = 1'b1; p[4] = 1'b1;
    run_loop(p, 30, -1, 0);
    for (int r = 0; r < 4; r++) run_loop($urandom, 30, -1, 0);
    run_loop({1'b1, 31'($urandom)}, 30, -1, 0);

    // R10 single flip
    run_loop(p, 20, 8, 0);

    // R5 junk history before sync
    run_loop($urandom, 20, -1, 2);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule